// File: doc/BRIEF.md
# Strided Interleave DMA Address Generator

This block produces the quadword address pairs for an interleaved block copy between main memory and a scratchpad. A start pulse gives it a total quadword count, a transfer length, a skip length and two start addresses. The total is cut into chunks of the transfer length. Inside a chunk both addresses step by 16 bytes. At the end of each chunk the main-memory address also jumps over the skip length. The scratchpad address stays contiguous for the whole block. A transfer length of zero means the whole block is one chunk.

Each beat carries one source and one destination address under a valid/ready handshake. A direction input chooses which side is the source. A one-cycle done pulse marks the end of the block. Moving the data, the memories themselves and interrupt handling belong to other blocks.

Top module: `stride_dma_agen`

## Requirements
- R1: After reset, `beat_valid_o`, `done_o` and `busy_o` are low.
- R2: A start accepted with total N > 0 gives exactly N accepted beats. `done_o` is high for exactly one cycle, in the cycle after the edge that accepts the last beat, and `beat_valid_o` is low in that cycle.
- R3: The scratchpad address of beat k (counting from 0) is its 16-byte-aligned start address plus 16*k.
- R4: With an effective chunk length L, the main-memory address of beat k is its aligned start address plus 16*(k + skip*floor(k/L)). Inside a chunk it steps by 16; across a chunk boundary it steps by 16*(skip+1).
- R5: A transfer length of 0 makes L equal to the total count, so the main-memory side is contiguous and the skip value has no effect.
- R6: When the remaining count is smaller than L, the last chunk holds only the remaining beats, and no beat is produced after the N-th.
- R7: While `beat_valid_o` is high and `beat_ready_i` is low, `beat_valid_o` stays high and both address outputs hold their values in the next cycle.
- R8: A start with total 0 gives `done_o` high in the next cycle and no beat.
- R9: With `dir_i` = 0, `src_addr_o` carries the main-memory (strided) address and `dst_addr_o` the scratchpad address. With `dir_i` = 1 the two are swapped.
- R10: A start pulse while `busy_o` is high is ignored: the running block keeps its addresses and beat count.
- R11: Address bits [3:0] on both outputs are always 0, whatever the low bits of the start addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| dir_i | input | 1 | 0: main memory is the source; 1: main memory is the destination |
| total_qw_i | input | 16 | Total quadword count |
| xfer_qw_i | input | 16 | Chunk length in quadwords, 0 = whole block |
| skip_qw_i | input | 16 | Quadwords skipped on the main-memory side after each chunk |
| main_addr_i | input | 32 | Main-memory start byte address |
| spad_addr_i | input | 32 | Scratchpad start byte address |
| busy_o | output | 1 | Block in progress |
| beat_valid_o | output | 1 | Address pair valid |
| beat_ready_i | input | 1 | Consumer takes the beat |
| src_addr_o | output | 32 | Source quadword byte address |
| dst_addr_o | output | 32 | Destination quadword byte address |
| done_o | output | 1 | One-cycle pulse when the block completes |

## Verification
Two functions can fall in the same cycle: the skip jump at a chunk boundary, and back-pressure holding the beat that closes the chunk. The bench uses chunk lengths of 1 and 2 together with a random ready that is often low. This puts many boundary beats under a stall. Each stall is judged by comparing the held addresses with the previous cycle. Each accepted beat is judged against the closed-form address formula, which also covers the case where the final chunk boundary and the last beat coincide.

// File: rtl/sdag_pkg.sv
package sdag_pkg;
  typedef enum logic {
    DIR_FROM_MAIN = 1'b0,
    DIR_TO_MAIN   = 1'b1
  } sdag_dir_e;
endpackage

// File: rtl/sdag_count.sv
module sdag_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [CNT_W-1:0] xfer_i,
  input  logic             step_i,
  output logic             last_o,
  output logic             chunk_end_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q, chunk_q, len_q;
  logic [CNT_W-1:0] len_d;

  // zero chunk length means one chunk for the whole block
  assign len_d = (xfer_i == '0) ? total_i : xfer_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      chunk_q <= '0;
      len_q   <= '0;
    end else if (load_i) begin
      rem_q   <= total_i;
      chunk_q <= len_d;
      len_q   <= len_d;
    end else if (step_i) begin
      rem_q   <= rem_q - ONE;
      chunk_q <= (chunk_q == ONE) ? len_q : chunk_q - ONE;
    end
  end

  assign last_o      = (rem_q == ONE);
  assign chunk_end_o = (chunk_q == ONE);

  // R6: an open block always has a chunk in progress
  a_r6_chunk_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q != '0) |-> (chunk_q != '0));
  // R2: each step consumes exactly one quadword
  a_r2_rem_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && rem_q != '0) |=> (rem_q == $past(rem_q) - ONE));
endmodule

// File: rtl/sdag_addr.sv
module sdag_addr #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] main_i,
  input  logic [ADDR_W-1:0] spad_i,
  input  logic [CNT_W-1:0]  skip_i,
  input  logic              step_i,
  input  logic              chunk_end_i,
  output logic [ADDR_W-1:0] main_o,
  output logic [ADDR_W-1:0] spad_o
);
  localparam int QW_W = ADDR_W - 4;
  localparam logic [QW_W-1:0] QW_ONE = QW_W'(1);

  logic [QW_W-1:0]  main_q, spad_q;
  logic [CNT_W-1:0] skip_q;
  logic [QW_W-1:0]  main_inc;

  assign main_inc = chunk_end_i ? (QW_W'(skip_q) + QW_ONE) : QW_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
      spad_q <= '0;
      skip_q <= '0;
    end else if (load_i) begin
      main_q <= main_i[ADDR_W-1:4];
      spad_q <= spad_i[ADDR_W-1:4];
      skip_q <= skip_i;
    end else if (step_i) begin
      main_q <= main_q + main_inc;
      spad_q <= spad_q + QW_ONE;
    end
  end

  assign main_o = {main_q, 4'b0000};
  assign spad_o = {spad_q, 4'b0000};

  // R4: inside a chunk the strided side moves one quadword
  a_r4_in_chunk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !chunk_end_i) |=> (main_o == $past(main_o) + ADDR_W'(16)));
  // R3: scratchpad side stays contiguous
  a_r3_spad_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (spad_o == $past(spad_o) + ADDR_W'(16)));
endmodule

// File: rtl/stride_dma_agen.sv
module stride_dma_agen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [CNT_W-1:0]  total_qw_i,
  input  logic [CNT_W-1:0]  xfer_qw_i,
  input  logic [CNT_W-1:0]  skip_qw_i,
  input  logic [ADDR_W-1:0] main_addr_i,
  input  logic [ADDR_W-1:0] spad_addr_i,
  output logic              busy_o,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              done_o
);
  import sdag_pkg::*;

  logic      busy_q, done_q;
  sdag_dir_e dir_q;
  logic      accept, load, fire, last, chunk_end;
  logic [ADDR_W-1:0] main_a, spad_a;

  assign accept = start_i && !busy_q;
  assign load   = accept && (total_qw_i != '0);
  assign fire   = busy_q && beat_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= DIR_FROM_MAIN;
    end else begin
      done_q <= (accept && (total_qw_i == '0)) || (fire && last);
      if (load) begin
        busy_q <= 1'b1;
        dir_q  <= sdag_dir_e'(dir_i);
      end else if (fire && last) begin
        busy_q <= 1'b0;
      end
    end
  end

  sdag_count #(.CNT_W(CNT_W)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .total_i     (total_qw_i),
    .xfer_i      (xfer_qw_i),
    .step_i      (fire),
    .last_o      (last),
    .chunk_end_o (chunk_end)
  );

  sdag_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .main_i      (main_addr_i),
    .spad_i      (spad_addr_i),
    .skip_i      (skip_qw_i),
    .step_i      (fire),
    .chunk_end_i (chunk_end),
    .main_o      (main_a),
    .spad_o      (spad_a)
  );

  assign busy_o       = busy_q;
  assign beat_valid_o = busy_q;
  assign done_o       = done_q;
  assign src_addr_o   = (dir_q == DIR_TO_MAIN) ? spad_a : main_a;
  assign dst_addr_o   = (dir_q == DIR_TO_MAIN) ? main_a : spad_a;

  // R7: stalled beat is held
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_ready_i) |=>
      (beat_valid_o && $stable(src_addr_o) && $stable(dst_addr_o)));
  // R2: done is a single-cycle pulse with no beat alongside
  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !beat_valid_o);
  // R10: start while busy leaves the addresses alone
  a_r10_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !beat_ready_i) |=> $stable(src_addr_o));
  // R11: quadword alignment
  a_r11_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_addr_o[3:0] == 4'h0) && (dst_addr_o[3:0] == 4'h0));
endmodule

// File: tb/sim_stride_dma_agen.sv
module sim_stride_dma_agen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_i = 1'b0;
  logic [15:0] total_qw_i = '0, xfer_qw_i = '0, skip_qw_i = '0;
  logic [31:0] main_addr_i = '0, spad_addr_i = '0;
  logic        busy_o, beat_valid_o, done_o;
  logic        beat_ready_i = 1'b0;
  logic [31:0] src_addr_o, dst_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  stride_dma_agen u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_main(input logic [31:0] base, input int k, input int len, input int skip);
    return {base[31:4], 4'h0} + 32'(16 * (k + skip * (k / len)));
  endfunction

  function automatic logic [31:0] exp_spad(input logic [31:0] base, input int k);
    return {base[31:4], 4'h0} + 32'(16 * k);
  endfunction

  task automatic run(input logic d, input int tot, input int xf, input int sk,
                     input logic [31:0] ma, input logic [31:0] sa,
                     input int rdy_pct, input bit poke);
    int len;
    int beats;
    bit prev_valid, prev_rdy, rdy;
    logic [31:0] prev_src, prev_dst, em, es, xs, xd;
    len = (xf == 0) ? tot : xf;
    @(negedge clk_i);
    dir_i = d; total_qw_i = 16'(tot); xfer_qw_i = 16'(xf); skip_qw_i = 16'(sk);
    main_addr_i = ma; spad_addr_i = sa; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (tot == 0) begin
      chk(done_o === 1'b1, "R8 done after zero start", 32'(done_o), 32'd1);
      chk(beat_valid_o === 1'b0, "R8 no beat", 32'(beat_valid_o), 32'd0);
      @(negedge clk_i);
      chk(done_o === 1'b0 && beat_valid_o === 1'b0, "R8 single pulse", 32'(done_o), 32'd0);
      return;
    end
    beats = 0; prev_valid = 0; prev_rdy = 0;
    while (beats < tot) begin
      start_i = 1'b0;
      chk(beat_valid_o === 1'b1, "R2 valid while open", 32'(beat_valid_o), 32'd1);
      chk(done_o === 1'b0, "R2 no early done", 32'(done_o), 32'd0);
      em = exp_main(ma, beats, len, sk);
      es = exp_spad(sa, beats);
      xs = d ? es : em;
      xd = d ? em : es;
      chk(src_addr_o === xs, d ? "R3 R9 src scratchpad" : "R4 R9 src main", src_addr_o, xs);
      chk(dst_addr_o === xd, d ? "R4 R9 dst main" : "R3 R9 dst scratchpad", dst_addr_o, xd);
      if (prev_valid && !prev_rdy) begin
        chk(src_addr_o === prev_src, "R7 src held", src_addr_o, prev_src);
        chk(dst_addr_o === prev_dst, "R7 dst held", dst_addr_o, prev_dst);
      end
      rdy = ($urandom % 100) < rdy_pct;
      beat_ready_i = rdy;
      if (poke && beats == 1) begin
        // R10: start while busy with other parameters
        start_i = 1'b1; total_qw_i = 16'd3; xfer_qw_i = 16'd1; skip_qw_i = 16'd7;
        main_addr_i = 32'h0BAD_0000; spad_addr_i = 32'h0BAD_1000; dir_i = ~d;
      end
      prev_valid = 1; prev_rdy = rdy; prev_src = src_addr_o; prev_dst = dst_addr_o;
      if (rdy) beats++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    beat_ready_i = 1'b0;
    chk(done_o === 1'b1, "R2 R6 done after last beat", 32'(done_o), 32'd1);
    chk(beat_valid_o === 1'b0, "R6 no beat beyond total", 32'(beat_valid_o), 32'd0);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R2 done one cycle", 32'(done_o), 32'd0);
    chk(busy_o === 1'b0 && beat_valid_o === 1'b0, "R6 idle after block", 32'(busy_o), 32'd0);
  endtask

  initial begin
    #500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(beat_valid_o === 1'b0 && done_o === 1'b0 && busy_o === 1'b0, "R1 reset state", 32'(beat_valid_o), 32'd0);
    #11;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(beat_valid_o === 1'b0 && done_o === 1'b0 && busy_o === 1'b0, "R1 idle after reset", 32'(busy_o), 32'd0);
    // directed corners
    run(1'b0, 0, 3, 2, 32'h100, 32'h200, 100, 0);                  // R8
    run(1'b0, 7, 0, 9, 32'h0001_0000, 32'h0000_4000, 100, 0);      // R5
    run(1'b1, 7, 0, 9, 32'h0002_0000, 32'h0000_1000, 50, 0);       // R5 R9
    run(1'b0, 6, 3, 2, 32'h0003_0000, 32'h0, 100, 0);              // exact multiple
    run(1'b0, 7, 3, 1, 32'h0004_0007, 32'h0000_000F, 100, 0);      // R6 R11
    run(1'b1, 5, 1, 4, 32'h0005_0000, 32'h0000_2000, 30, 0);       // R7 at every boundary
    run(1'b0, 4, 9, 5, 32'h0006_0000, 32'h0000_3000, 60, 0);       // R6 chunk longer than block
    run(1'b0, 6, 2, 3, 32'h0007_0000, 32'h0000_5000, 40, 1);       // R10
    run(1'b1, 8, 2, 1, 32'hFFFF_FF80, 32'h0000_6000, 70, 1);       // R10 wrap
    run(1'b0, 1, 1, 5, 32'h0008_0000, 32'h0000_7000, 100, 0);      // single beat
    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      run(1'($urandom % 2), int'($urandom % 24), int'($urandom % 6), int'($urandom % 6),
          $urandom, $urandom, 25 + int'($urandom % 76), bit'(($urandom % 4) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule